// File: doc/BRIEF.md
# External Bus Grant Arbiter

This block decides who drives the chip's external bus: the on-chip bus master, or an external master that takes the bus through a three-wire handshake. The three wires are a request input, a grant output and a grant-acknowledge input. The arbiter gives a grant only when doing so cannot split work that must stay atomic. That work is a multi-cycle operand transfer by the on-chip master, or a locked read-modify-write sequence.

A two-bit show-cycle mode field sets how internal-only accesses interact with the grant. In one mode they block it. In another they run on in parallel with the external master. In the third mode the bus is never granted at all. A synchronous-mode input selects how the handshake inputs are sampled: directly, or through a two-flop synchronizer.

On the internal side, the arbiter tells the on-chip cycle engine two things: whether the chip still owns the bus, and whether a new external cycle may start now. That second signal also sets how soon the chip reclaims the bus after an external master lets go.

Top module: `ext_bus_arbiter`

## Requirements
- R1: After reset, grant_o is 0 and both int_owns_o and start_ok_o are 1.
- R2: With sync_mode=1, grant_o rises on the first clock edge that samples ext_req_i high. With sync_mode=0, ext_req_i and ext_ack_i each pass through two flops first, so grant_o rises on the third edge.
- R3: No grant is given at an edge where xfer_act_i is 1. No grant is given while an operand is still open: one of its cycles ended (xfer_act_i and cyc_done_i both 1) with op_last_i=0, and no later cycle has ended with op_last_i=1.
- R4: No grant is given at an edge where rmw_lock_i is 1.
- R5: With show_mode=2'b10 or 2'b11, no grant is given while int_cyc_act_i is 1. With show_mode=2'b00, int_cyc_act_i does not delay the grant.
- R6: With show_mode=2'b01, grant_o never asserts.
- R7: grant_o negates on the edge that samples the acknowledge high, and int_owns_o goes to 0 at the same edge. While the acknowledge is held, grant_o stays 0 whatever ext_req_i does.
- R8: If the request is sampled low while the grant is pending and no acknowledge has arrived, grant_o negates on that edge and start_ok_o returns to 1.
- R9: The bus is reclaimed after the acknowledge is sampled low with no request pending. With sync_mode=1 and show_mode=2'b00, start_ok_o and int_owns_o are 1 after that same edge. show_mode=2'b1x adds one more edge. sync_mode=0 adds two edges of synchronizer delay.
- R10: If a request is pending when the acknowledge is sampled low, grant_o reasserts on that edge and start_ok_o stays 0.
- R11: start_ok_o is 0 whenever the grant is pending or an external master owns the bus. If int_ext_req_i and start_ok_o are both 1 at an edge, the internal start wins and no grant is given on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: sample the handshake inputs directly; 0: pass them through the synchronizer |
| show_mode | input | 2 | Show-cycle mode: 00 grant in parallel with internal accesses, 01 never grant, 1x wait for internal accesses to end |
| ext_req_i | input | 1 | Bus request from an external master |
| ext_ack_i | input | 1 | Grant acknowledge; while high, an external master owns the bus |
| int_ext_req_i | input | 1 | The on-chip engine wants to start an external cycle at this edge |
| xfer_act_i | input | 1 | The on-chip engine is running an external bus cycle |
| op_last_i | input | 1 | The current cycle is the last one of its operand |
| cyc_done_i | input | 1 | The current external cycle terminates at this edge |
| rmw_lock_i | input | 1 | Read-modify-write lock |
| int_cyc_act_i | input | 1 | An internal-only access is in progress |
| grant_o | output | 1 | Bus grant to external masters |
| int_owns_o | output | 1 | The on-chip master owns the external bus |
| start_ok_o | output | 1 | The on-chip engine may start an external cycle |

## Verification
The hardest case to reach is the gap inside an operand. One cycle of the operand has ended without its last-cycle flag, and xfer_act_i is low for a cycle before the next one starts. At that point only the arbiter's own memory of the open operand holds the grant back. The bench drives a request while the transfer is active, ends one cycle with op_last_i low, and idles the engine for a cycle. It checks that grant_o stays low through that gap, and that it rises only after a cycle ends with op_last_i high. A second hard case is a request and an internal start arriving at the same edge. The bench drives both in the same cycle to show that the internal start wins.

// File: rtl/ebg_pkg.sv
package ebg_pkg;
  typedef enum logic [1:0] {
    ST_INT     = 2'd0,
    ST_GRANT   = 2'd1,
    ST_EXT     = 2'd2,
    ST_RECLAIM = 2'd3
  } ebg_state_t;

  localparam logic [1:0] SHOW_PARALLEL = 2'b00;
  localparam logic [1:0] SHOW_NOGRANT  = 2'b01;
endpackage

// File: rtl/ebg_sync.sv
module ebg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ebg_gate.sv
module ebg_gate
  import ebg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] show_mode,
  input  logic       xfer_act_i,
  input  logic       op_last_i,
  input  logic       cyc_done_i,
  input  logic       rmw_lock_i,
  input  logic       int_cyc_act_i,
  input  logic       int_ext_req_i,
  input  logic       start_ok,
  output logic       grant_ok
);
  // Remembers that an operand is split across bus cycles and not yet finished
  logic opnd_open;
  logic cyc_end;

  assign cyc_end = xfer_act_i && cyc_done_i;

  always_ff @(posedge clk) begin
    if (rst)          opnd_open <= 1'b0;
    else if (cyc_end) opnd_open <= !op_last_i;
  end

  logic hold_coherent, hold_show, hold_start;

  assign hold_coherent = xfer_act_i || opnd_open || rmw_lock_i;
  assign hold_show     = (show_mode == SHOW_NOGRANT) || (show_mode[1] && int_cyc_act_i);
  assign hold_start    = start_ok && int_ext_req_i;
  assign grant_ok      = !(hold_coherent || hold_show || hold_start);
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import ebg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_mode,
  input  logic [1:0] show_mode,
  input  logic       ext_req_i,
  input  logic       ext_ack_i,
  input  logic       int_ext_req_i,
  input  logic       xfer_act_i,
  input  logic       op_last_i,
  input  logic       cyc_done_i,
  input  logic       rmw_lock_i,
  input  logic       int_cyc_act_i,
  output logic       grant_o,
  output logic       int_owns_o,
  output logic       start_ok_o
);
  logic [1:0] sync_q;
  logic       req_s, ack_s, grant_ok;
  ebg_state_t st, nxt;

  ebg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_req_i, ext_ack_i}),
    .q   (sync_q)
  );

  assign req_s = sync_mode ? ext_req_i : sync_q[1];
  assign ack_s = sync_mode ? ext_ack_i : sync_q[0];

  ebg_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .show_mode     (show_mode),
    .xfer_act_i    (xfer_act_i),
    .op_last_i     (op_last_i),
    .cyc_done_i    (cyc_done_i),
    .rmw_lock_i    (rmw_lock_i),
    .int_cyc_act_i (int_cyc_act_i),
    .int_ext_req_i (int_ext_req_i),
    .start_ok      (start_ok_o),
    .grant_ok      (grant_ok)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_INT:     if (req_s && grant_ok) nxt = ST_GRANT;
      ST_GRANT: begin
        if (ack_s)       nxt = ST_EXT;
        else if (!req_s) nxt = ST_INT;
      end
      ST_EXT: begin
        if (!ack_s) begin
          if (req_s && grant_ok)  nxt = ST_GRANT;
          else if (show_mode[1])  nxt = ST_RECLAIM;
          else                    nxt = ST_INT;
        end
      end
      ST_RECLAIM: nxt = ST_INT;
      default:    nxt = ST_INT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_INT;
      grant_o    <= 1'b0;
      int_owns_o <= 1'b1;
      start_ok_o <= 1'b1;
    end else begin
      st         <= nxt;
      grant_o    <= (nxt == ST_GRANT);
      int_owns_o <= (nxt != ST_EXT);
      start_ok_o <= (nxt == ST_INT);
    end
  end
endmodule

// File: rtl/ext_bus_arbiter_chk.sv
module ext_bus_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_mode,
  input logic [1:0] show_mode,
  input logic       ext_ack_i,
  input logic       int_ext_req_i,
  input logic       xfer_act_i,
  input logic       rmw_lock_i,
  input logic       int_cyc_act_i,
  input logic       grant_o,
  input logic       start_ok_o
);
  AST_XFER_HOLDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (xfer_act_i && !grant_o) |=> !grant_o); // R3
  AST_LOCK_HOLDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (rmw_lock_i && !grant_o) |=> !grant_o); // R4
  AST_SHOW_WAITS_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    (show_mode[1] && int_cyc_act_i && !grant_o) |=> !grant_o); // R5
  AST_NOGRANT_MODE: assert property (@(posedge clk) disable iff (rst)
    (show_mode == 2'b01 && !grant_o) |=> !grant_o); // R6
  AST_ACK_DROPS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && ext_ack_i && grant_o) |=> !grant_o); // R7
  AST_INTERNAL_START_WINS: assert property (@(posedge clk) disable iff (rst)
    (start_ok_o && int_ext_req_i && !grant_o) |=> !grant_o); // R11
endmodule

bind ext_bus_arbiter ext_bus_arbiter_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .sync_mode     (sync_mode),
  .show_mode     (show_mode),
  .ext_ack_i     (ext_ack_i),
  .int_ext_req_i (int_ext_req_i),
  .xfer_act_i    (xfer_act_i),
  .rmw_lock_i    (rmw_lock_i),
  .int_cyc_act_i (int_cyc_act_i),
  .grant_o       (grant_o),
  .start_ok_o    (start_ok_o)
);

// File: tb/tb_ext_bus_arbiter.sv
module tb_ext_bus_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode = 1'b1;
  logic [1:0] show_mode = 2'b00;
  logic ext_req = 1'b0, ext_ack = 1'b0, int_ext_req = 1'b0;
  logic xfer_act = 1'b0, op_last = 1'b0, cyc_done = 1'b0;
  logic rmw_lock = 1'b0, int_cyc_act = 1'b0;
  logic grant, int_owns, start_ok;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  ext_bus_arbiter dut (
    .clk (clk), .rst (rst), .sync_mode (sync_mode), .show_mode (show_mode),
    .ext_req_i (ext_req), .ext_ack_i (ext_ack), .int_ext_req_i (int_ext_req),
    .xfer_act_i (xfer_act), .op_last_i (op_last), .cyc_done_i (cyc_done),
    .rmw_lock_i (rmw_lock), .int_cyc_act_i (int_cyc_act),
    .grant_o (grant), .int_owns_o (int_owns), .start_ok_o (start_ok)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sm, input logic [1:0] mode);
    rst = 1'b1; sync_mode = sm; show_mode = mode;
    ext_req = 0; ext_ack = 0; int_ext_req = 0; xfer_act = 0;
    op_last = 0; cyc_done = 0; rmw_lock = 0; int_cyc_act = 0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b1, 2'b00);
    chk("R1 grant", grant, 1'b0);
    chk("R1 owns", int_owns, 1'b1);
    chk("R1 start_ok", start_ok, 1'b1);
  endtask

  task automatic t_sync_cycle;
    do_reset(1'b1, 2'b00);
    ext_req = 1; step(1);
    chk("R2 sync grant", grant, 1'b1);
    chk("R11 start_ok while granted", start_ok, 1'b0);
    ext_ack = 1; step(1);
    chk("R7 grant drops on ack", grant, 1'b0);
    chk("R7 owns drops", int_owns, 1'b0);
    ext_req = 0; step(1);
    ext_req = 1; step(3);
    chk("R7 no grant while ack held", grant, 1'b0);
    chk("R11 start_ok while ext owns", start_ok, 1'b0);
    ext_req = 0; step(1);
    ext_ack = 0; step(1);
    chk("R9 sync 00 reclaim start_ok", start_ok, 1'b1);
    chk("R9 sync 00 reclaim owns", int_owns, 1'b1);
  endtask

  task automatic t_async_cycle;
    do_reset(1'b0, 2'b00);
    ext_req = 1; step(2);
    chk("R2 async grant not yet", grant, 1'b0);
    step(1);
    chk("R2 async grant", grant, 1'b1);
    ext_ack = 1; ext_req = 0; step(2);
    chk("R7 async grant held", grant, 1'b1);
    step(1);
    chk("R7 async grant drops", grant, 1'b0);
    ext_ack = 0; step(2);
    chk("R9 async reclaim not yet", start_ok, 1'b0);
    step(1);
    chk("R9 async reclaim", start_ok, 1'b1);
  endtask

  task automatic t_show1x_reclaim;
    do_reset(1'b1, 2'b10);
    ext_req = 1; step(1);
    ext_ack = 1; ext_req = 0; step(1);
    ext_ack = 0; step(1);
    chk("R9 1x extra clock start_ok", start_ok, 1'b0);
    chk("R9 1x owns back", int_owns, 1'b1);
    step(1);
    chk("R9 1x reclaim", start_ok, 1'b1);
  endtask

  task automatic t_show_modes;
    do_reset(1'b1, 2'b11);
    int_cyc_act = 1; ext_req = 1; step(3);
    chk("R5 1x held by internal access", grant, 1'b0);
    int_cyc_act = 0; step(1);
    chk("R5 1x grant after internal end", grant, 1'b1);
    ext_req = 0; step(1);
    chk("R8 req drop negates grant", grant, 1'b0);
    chk("R8 req drop start_ok", start_ok, 1'b1);
    show_mode = 2'b00; int_cyc_act = 1; ext_req = 1; step(1);
    chk("R5 00 grant in parallel", grant, 1'b1);
    ext_req = 0; int_cyc_act = 0; step(1);
    show_mode = 2'b01; ext_req = 1; step(5);
    chk("R6 never grant", grant, 1'b0);
    chk("R6 start_ok kept", start_ok, 1'b1);
    ext_req = 0; step(1);
  endtask

  task automatic t_coherency;
    do_reset(1'b1, 2'b00);
    xfer_act = 1; ext_req = 1; step(2);
    chk("R3 held during cycle", grant, 1'b0);
    cyc_done = 1; op_last = 0; step(1);
    xfer_act = 0; cyc_done = 0; step(1);
    chk("R3 held in operand gap", grant, 1'b0);
    xfer_act = 1; cyc_done = 1; op_last = 1; step(1);
    chk("R3 held on last cycle", grant, 1'b0);
    xfer_act = 0; cyc_done = 0; op_last = 0; step(1);
    chk("R3 grant after operand end", grant, 1'b1);
    ext_req = 0; step(1);
  endtask

  task automatic t_rmw;
    do_reset(1'b1, 2'b00);
    rmw_lock = 1; ext_req = 1; step(3);
    chk("R4 held by lock", grant, 1'b0);
    rmw_lock = 0; step(1);
    chk("R4 grant after unlock", grant, 1'b1);
    ext_req = 0; step(1);
    chk("R8 grant withdrawn", grant, 1'b0);
    chk("R8 owns kept", int_owns, 1'b1);
  endtask

  task automatic t_regrant;
    do_reset(1'b1, 2'b00);
    ext_req = 1; step(1);
    ext_ack = 1; step(1);
    ext_ack = 0; step(1);
    chk("R10 regrant on release", grant, 1'b1);
    chk("R10 start_ok stays low", start_ok, 1'b0);
    ext_ack = 1; ext_req = 0; step(1);
    ext_ack = 0; step(1);
    chk("R10 reclaim after second master", start_ok, 1'b1);
  endtask

  task automatic t_int_wins;
    do_reset(1'b1, 2'b00);
    int_ext_req = 1; ext_req = 1; step(1);
    chk("R11 internal start wins", grant, 1'b0);
    int_ext_req = 0; xfer_act = 1; cyc_done = 1; op_last = 1; step(1);
    chk("R11 held by started cycle", grant, 1'b0);
    xfer_act = 0; cyc_done = 0; op_last = 0; step(1);
    chk("R11 grant after cycle", grant, 1'b1);
    ext_req = 0; step(1);
  endtask

  initial begin
    t_reset();
    t_sync_cycle();
    t_async_cycle();
    t_show1x_reclaim();
    t_show_modes();
    t_coherency();
    t_rmw();
    t_regrant();
    t_int_wins();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule